// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the word address stream for a single DMA channel. In line mode it walks a rectangular region: a fixed number of lines, each a run of consecutive 32-bit words, with a programmable stride between the starts of successive lines. The stride may exceed the line length, so a gap can be skipped at the end of each line. All quantities are in words. Software converts a byte address to a word address by dropping its two low bits before it loads the block.

A zero line length selects loop mode. The block then sweeps a ring of `stride * (line count + 1)` words without end. It wraps to the start address after the last word. It pulses an event when the first half of the ring has been consumed and again when the second half has been consumed, so a consumer can refill one half while the other is in use. The line-count field always holds the number of lines minus one.

The direction bit and the burst bit are captured at launch and presented alongside the addresses. A start pulse launches the transfer once the other settings are in place. A synchronous stop abandons a transfer at once.

Top module: `dma2d_addr_seq`

## Requirements
- R1: While idle, valid_o, done_o and half_o are low. A start pulse while idle and stop is low captures all settings, and in the next cycle valid_o is high with addr_o equal to cfg_base.
- R2: In line mode (cfg_line_len nonzero), the words run in order base + r*stride + c, for c from 0 to line_len-1 and r from 0 to line_cnt. A line_cnt of 0 gives exactly one line.
- R3: addr_o changes only after a cycle in which valid_o and ready are both high. In any other cycle of a running transfer, addr_o and valid_o hold.
- R4: In line mode, one cycle after the handshake of the last word, done_o is high for exactly one cycle and valid_o is low (idle).
- R5: In loop mode (cfg_line_len of 0), the word at offset k is base + (k mod area), with area = stride*(line_cnt+1). The transfer continues until stopped.
- R6: In loop mode, half_o pulses for one cycle after the handshake of the word at offset area/2-1 (rounded down) with half_sel_o = 0, and after the word at offset area-1 with half_sel_o = 1. No other cycle carries half_o.
- R7: One cycle after stop is high, valid_o, done_o and half_o are low. This holds even when the stop coincides with the final handshake or with a start pulse.
- R8: burst_o is high exactly when valid_o is high, the captured burst bit is 1, and addr_o[1:0] is 00 (the first word of an aligned group of four).
- R9: dir_o shows the captured direction bit (1 memory to device, 0 device to memory) for the whole transfer.
- R10: A start pulse and any change on the cfg_ inputs while a transfer runs have no effect on the address stream or the events.
- R11: Addresses advance modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Start word address |
| cfg_line_len | input | LEN_W | Words per line; 0 selects loop mode |
| cfg_line_cnt | input | CNT_W | Number of lines minus one |
| cfg_stride | input | STRIDE_W | Words from one line start to the next |
| cfg_to_dev | input | 1 | Direction: 1 memory to device, 0 device to memory |
| cfg_burst4 | input | 1 | 1 selects 4-word bursts |
| start | input | 1 | Launch pulse |
| stop | input | 1 | Synchronous abort |
| ready | input | 1 | Consumer accepts the current word |
| addr_o | output | ADDR_W | Current word address |
| valid_o | output | 1 | addr_o is a live request |
| burst_o | output | 1 | First word of an aligned burst of four |
| dir_o | output | 1 | Captured direction |
| done_o | output | 1 | Line-mode completion pulse |
| half_o | output | 1 | Loop-mode half-buffer pulse |
| half_sel_o | output | 1 | Which half completed (0 first, 1 second) |

## Verification
The stop input and a transfer's natural end can fall on the same cycle. The bench provokes this by raising stop together with ready on the last word of a line-mode transfer. It requires that the next cycle shows the block idle and no done pulse. It also raises stop together with start while idle and expects nothing to launch. A start pulse with scrambled settings in the middle of a loop-mode sweep is judged by the unchanged address sequence and half events.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LINE = 2'd1,
        SQ_RING = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dma2d_line_walk.sv
module dma2d_line_walk #(
    parameter int ADDR_W   = 30,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                last_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] line;
        logic [LEN_W-1:0]  col;
        logic [CNT_W-1:0]  row;
    } walk_t;

    walk_t w_d, w_q;
    logic  line_end;
    logic [ADDR_W-1:0] next_line;

    assign line_end  = (w_q.col == len_i - LEN_W'(1));
    assign next_line = w_q.line + ADDR_W'(stride_i);

    always_comb begin
        w_d = w_q;
        if (load_i) begin
            w_d.addr = base_i;
            w_d.line = base_i;
            w_d.col  = '0;
            w_d.row  = '0;
        end else if (step_i) begin
            if (line_end) begin
                w_d.line = next_line;
                w_d.addr = next_line;
                w_d.col  = '0;
                w_d.row  = w_q.row + CNT_W'(1);
            end else begin
                w_d.addr = w_q.addr + ADDR_W'(1);
                w_d.col  = w_q.col + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign addr_o = w_q.addr;
    assign last_o = line_end && (w_q.row == cnt_i);

    // R2
    col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i != '0) |-> (w_q.col < len_i));
endmodule

// File: rtl/dma2d_ring_walk.sv
module dma2d_ring_walk #(
    parameter int ADDR_W = 30,
    parameter int AREA_W = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [AREA_W-1:0] area_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              end_first_o,
    output logic              end_second_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [AREA_W-1:0] idx;
    } ring_t;

    ring_t r_d, r_q;
    logic [AREA_W-1:0] half_len;

    assign half_len     = area_i >> 1;
    assign end_first_o  = (half_len != '0) && (r_q.idx == half_len - AREA_W'(1));
    assign end_second_o = (r_q.idx == area_i - AREA_W'(1));

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.addr = base_i;
            r_d.idx  = '0;
        end else if (step_i) begin
            if (end_second_o) begin
                r_d.addr = base_i;
                r_d.idx  = '0;
            end else begin
                r_d.addr = r_q.addr + ADDR_W'(1);
                r_d.idx  = r_q.idx + AREA_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_o = r_q.addr;

    // R5
    ring_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (area_i != '0) |-> (r_q.idx < area_i));
endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq
    import dma2d_pkg::*;
#(
    parameter int ADDR_W   = 30,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [LEN_W-1:0]    cfg_line_len,
    input  logic [CNT_W-1:0]    cfg_line_cnt,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic                cfg_to_dev,
    input  logic                cfg_burst4,
    input  logic                start,
    input  logic                stop,
    input  logic                ready,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                valid_o,
    output logic                burst_o,
    output logic                dir_o,
    output logic                done_o,
    output logic                half_o,
    output logic                half_sel_o
);
    localparam int AREA_W = STRIDE_W + CNT_W + 1;

    typedef struct packed {
        seq_state_e            st;
        logic [ADDR_W-1:0]     base;
        logic [LEN_W-1:0]      len;
        logic [CNT_W-1:0]      cnt;
        logic [STRIDE_W-1:0]   stride;
        logic [AREA_W-1:0]     area;
        logic                  dir;
        logic                  burst;
        logic                  done;
        logic                  half;
        logic                  half_sel;
    } seq_t;

    seq_t s_d, s_q;

    logic              launch;
    logic              hs;
    logic [ADDR_W-1:0] walk_base;
    logic [AREA_W-1:0] area_calc;
    logic [ADDR_W-1:0] line_addr, ring_addr;
    logic              line_last, ring_first, ring_second;

    assign launch    = start && !stop && (s_q.st == SQ_IDLE);
    assign hs        = (s_q.st != SQ_IDLE) && ready;
    assign walk_base = launch ? cfg_base : s_q.base;
    assign area_calc = AREA_W'(cfg_stride) * (AREA_W'(cfg_line_cnt) + AREA_W'(1));

    dma2d_line_walk #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)
    ) u_line (
        .clk(clk), .rst_n(rst_n),
        .load_i(launch),
        .step_i(hs && (s_q.st == SQ_LINE)),
        .base_i(walk_base),
        .len_i(s_q.len),
        .cnt_i(s_q.cnt),
        .stride_i(s_q.stride),
        .addr_o(line_addr),
        .last_o(line_last)
    );

    dma2d_ring_walk #(
        .ADDR_W(ADDR_W), .AREA_W(AREA_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .load_i(launch),
        .step_i(hs && (s_q.st == SQ_RING)),
        .base_i(walk_base),
        .area_i(s_q.area),
        .addr_o(ring_addr),
        .end_first_o(ring_first),
        .end_second_o(ring_second)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.half = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (launch) begin
                    s_d.base   = cfg_base;
                    s_d.len    = cfg_line_len;
                    s_d.cnt    = cfg_line_cnt;
                    s_d.stride = cfg_stride;
                    s_d.area   = area_calc;
                    s_d.dir    = cfg_to_dev;
                    s_d.burst  = cfg_burst4;
                    s_d.st     = (cfg_line_len == '0) ? SQ_RING : SQ_LINE;
                end
            end
            SQ_LINE: begin
                if (stop) begin
                    s_d.st = SQ_IDLE;
                end else if (hs && line_last) begin
                    s_d.st   = SQ_IDLE;
                    s_d.done = 1'b1;
                end
            end
            SQ_RING: begin
                if (stop) begin
                    s_d.st = SQ_IDLE;
                end else if (hs && ring_first) begin
                    s_d.half     = 1'b1;
                    s_d.half_sel = 1'b0;
                end else if (hs && ring_second) begin
                    s_d.half     = 1'b1;
                    s_d.half_sel = 1'b1;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o    = (s_q.st != SQ_IDLE);
    assign addr_o     = (s_q.st == SQ_RING) ? ring_addr : line_addr;
    assign burst_o    = valid_o && s_q.burst && (addr_o[1:0] == 2'b00);
    assign dir_o      = s_q.dir;
    assign done_o     = s_q.done;
    assign half_o     = s_q.half;
    assign half_sel_o = s_q.half_sel;

    // R1
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(start));
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready && !stop) |=> (valid_o && $stable(addr_o)));
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);
    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!valid_o && !done_o && !half_o));
    // R6
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, half_o}));
    // R8
    burst_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> valid_o);
endmodule

// File: tb/dma2d_addr_seq_bench.sv
module dma2d_addr_seq_bench;
    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [15:0]   cfg_line_len = '0;
    logic [15:0]   cfg_line_cnt = '0;
    logic [15:0]   cfg_stride = '0;
    logic          cfg_to_dev = 1'b0;
    logic          cfg_burst4 = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          ready = 1'b0;
    logic [AW-1:0] addr_o;
    logic          valid_o, burst_o, dir_o, done_o, half_o, half_sel_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma2d_addr_seq u_dma2d_addr_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_base(cfg_base), .cfg_line_len(cfg_line_len),
        .cfg_line_cnt(cfg_line_cnt), .cfg_stride(cfg_stride),
        .cfg_to_dev(cfg_to_dev), .cfg_burst4(cfg_burst4),
        .start(start), .stop(stop), .ready(ready),
        .addr_o(addr_o), .valid_o(valid_o), .burst_o(burst_o),
        .dir_o(dir_o), .done_o(done_o), .half_o(half_o),
        .half_sel_o(half_sel_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] wa(input longint v);
        return v[AW-1:0];
    endfunction

    task automatic launch(input logic [AW-1:0] b, input int len, input int cnt,
                          input int strd, input bit dir, input bit bst);
        @(negedge clk);
        cfg_base = b; cfg_line_len = 16'(len); cfg_line_cnt = 16'(cnt);
        cfg_stride = 16'(strd); cfg_to_dev = dir; cfg_burst4 = bst;
        start = 1'b1; ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(valid_o == 1'b1, "R1 valid after start", valid_o, 1);
        chk(addr_o == b, "R1 first address", addr_o, b);
        chk(dir_o == dir, "R9 direction", dir_o, dir);
    endtask

    // evt: 0 none, 1 first half, 2 second half, 3 done
    task automatic word(input logic [AW-1:0] ea, input int evt, input bit bst,
                        input bit poke, input string tag);
        bit rdy;
        int n = 0;
        do begin
            chk(valid_o == 1'b1, "R3 valid held", valid_o, 1);
            chk(addr_o == ea, tag, addr_o, ea);
            chk(burst_o == (bst && ea[1:0] == 2'b00), "R8 burst flag", burst_o,
                (bst && ea[1:0] == 2'b00));
            if (poke && n == 0) begin
                start = 1'b1; cfg_base = ~cfg_base; cfg_line_len = 16'd7;
                cfg_stride = 16'd3;
            end else begin
                start = 1'b0;
            end
            rdy = ($urandom % 3) != 0;
            if (n >= 4) rdy = 1'b1;
            ready = rdy;
            @(negedge clk);
            n++;
        end while (!rdy);
        start = 1'b0; ready = 1'b0;
        chk(done_o == (evt == 3), "R4 done pulse", done_o, (evt == 3));
        chk(half_o == (evt == 1 || evt == 2), "R6 half pulse", half_o, (evt == 1 || evt == 2));
        if (evt == 1 || evt == 2)
            chk(half_sel_o == (evt == 2), "R6 half select", half_sel_o, (evt == 2));
    endtask

    task automatic run_line(input logic [AW-1:0] b, input int len, input int cnt,
                            input int strd, input bit dir, input bit bst,
                            input bit stop_last, input string tag);
        launch(b, len, cnt, strd, dir, bst);
        for (int r = 0; r <= cnt; r++) begin
            for (int c = 0; c < len; c++) begin
                logic [AW-1:0] ea;
                bit lst;
                ea  = wa(longint'(b) + longint'(r) * strd + c);
                lst = (r == cnt) && (c == len - 1);
                if (lst && stop_last) begin
                    chk(addr_o == ea, tag, addr_o, ea);
                    stop = 1'b1; ready = 1'b1;
                    @(negedge clk);
                    stop = 1'b0; ready = 1'b0;
                    chk(valid_o == 1'b0, "R7 stop at last word idles", valid_o, 0);
                    chk(done_o == 1'b0, "R7 stop suppresses done", done_o, 0);
                end else begin
                    word(ea, lst ? 3 : 0, bst, 1'b0, tag);
                end
            end
        end
        chk(valid_o == 1'b0, "R4 idle after last", valid_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R4 done one cycle", done_o, 0);
    endtask

    task automatic run_ring(input logic [AW-1:0] b, input int cnt, input int strd,
                            input bit bst, input int nw, input int poke_at);
        int area, hl;
        area = strd * (cnt + 1);
        hl   = area / 2;
        launch(b, 0, cnt, strd, 1'b0, bst);
        for (int k = 0; k < nw; k++) begin
            int idx, evt;
            idx = k % area;
            evt = (hl != 0 && idx == hl - 1) ? 1 : ((idx == area - 1) ? 2 : 0);
            word(wa(longint'(b) + idx), evt, bst, k == poke_at,
                 (k == poke_at + 1) ? "R10 start ignored while busy" : "R5 ring address");
        end
        stop = 1'b1; ready = ($urandom % 2) == 0;
        @(negedge clk);
        stop = 1'b0; ready = 1'b0;
        chk(valid_o == 1'b0, "R7 stop idles ring", valid_o, 0);
        chk(half_o == 1'b0, "R7 stop no half", half_o, 0);
        chk(done_o == 1'b0, "R7 stop no done", done_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R4 actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 1'b0, "R1 reset idle valid", valid_o, 0);
        chk(done_o == 1'b0, "R1 reset idle done", done_o, 0);
        chk(half_o == 1'b0, "R1 reset idle half", half_o, 0);

        // directed: single line, gapped lines, burst, direction
        run_line(30'h100, 5, 0, 5, 1'b1, 1'b0, 1'b0, "R2 single line");
        run_line(30'h200, 3, 2, 8, 1'b0, 1'b1, 1'b0, "R2 gapped lines");
        run_line(30'h3FFF_FFFE, 4, 1, 6, 1'b1, 1'b1, 1'b0, "R11 address wrap");
        // stop coinciding with the final handshake
        run_line(30'h40, 2, 1, 4, 1'b0, 1'b0, 1'b1, "R2 stop case");

        // stop together with start while idle
        @(negedge clk);
        cfg_line_len = 16'd2; start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk(valid_o == 1'b0, "R7 stop beats start", valid_o, 0);

        // loop mode, including a start pulse mid-run
        run_ring(30'h500, 1, 2, 1'b1, 9, 3);
        run_ring(30'h601, 0, 1, 1'b0, 3, -1);
        run_ring(30'h3FFF_FFFD, 2, 2, 1'b1, 14, 7);

        // constrained random line-mode runs
        for (int i = 0; i < 10; i++) begin
            int len, cnt, strd;
            len  = 1 + ($urandom % 6);
            cnt  = $urandom % 4;
            strd = len + ($urandom % 5);
            run_line(wa($urandom), len, cnt, strd, 1'($urandom), 1'($urandom),
                     1'b0, "R2 random line");
        end
        // constrained random loop-mode runs
        for (int i = 0; i < 4; i++) begin
            int cnt, strd;
            cnt  = $urandom % 4;
            strd = 1 + ($urandom % 4);
            run_ring(wa($urandom), cnt, strd, 1'($urandom),
                     2 * strd * (cnt + 1) + 3, -1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule